// File: doc/BRIEF.md
# Multi-IO SPI host shift engine

This block is a register-driven SPI host for serial-flash style traffic in which software owns chip select. Software picks the bus width and direction in an operation control word, asserts chip select through the configuration word, and then pushes 1 to 4 bytes at a time by writing one of four transmit aliases. The alias that was written decides how many bytes go out. The engine shifts them over 1, 2, 4 or 8 IO lines with a serial clock at half the system clock. It collects the same number of bytes from the lines and leaves them, left-aligned, in a one-word receive holding register.

Status bits let software poll for the end of a transfer and for unread receive data. A global enable gates all activity. Dropping the enable halts a running transfer and throws it away. Clock polarity, clock phase and the idle level of the data lines are set in the configuration word.

Top module: `msio_spi_host`

## Requirements
- R1: After reset the status word (offset 0x04) reads 0x0000000B, the enable word (0x10) reads 0, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_io_oe` is 0 and `spi_io_out` is 0.
- R2: A write to offset 0x18, 0x1C, 0x20 or 0x14 starts a transfer of 1, 2, 3 or 4 bytes respectively. The bytes leave least significant byte of the written word first, each byte most significant bit first, with 8·n/L serial clock pulses for n bytes on L lines.
- R3: Bits 7:6 of the control word (0x30) select L: code 0 = 1 line, 1 = 2, 2 = 4, 3 = 8. Lines 0..L-1 carry each group, with line L-1 holding the most significant bit of the group. In 1-line mode, data leaves on line 0 and is taken in from line 1.
- R4: The receive word (0x24) holds the n received bytes in its top n bytes. The last byte is in bits 31:24, each earlier byte sits 8 bits lower, and the unused low bytes are 0.
- R5: Status bit 0 (transmit empty) and bit 1 (transmit not full) read 0 for exactly 16·n/L system cycles after the accepted transmit write and 1 otherwise. Bit 2 (receive not empty) becomes 1 once the transfer ends, and bit 3 (receive not full) is its inverse.
- R6: Reading offset 0x24 returns the receive word and clears status bit 2.
- R7: With control bit 23 set (read direction), `spi_io_oe` stays 0 for the whole transfer.
- R8: `spi_cs_n` is 0 only while configuration bit 1 (manual select enable) and bit 0 (select assert) are both 1.
- R9: The serial clock idles at configuration bit 19 and toggles every system cycle during a transfer. With configuration bit 20 clear, the first half of each group holds the idle level; with bit 20 set, the first half holds the active level.
- R10: With enable bit 0 clear, transmit writes start nothing. Clearing it during a transfer ends the transfer with no receive word and returns the serial clock to idle.
- R11: Configuration bit 16 sets the level driven on every IO line that is not carrying transmit data.
- R12: The configuration word reads back bits 28:27, 20, 19, 16, 1 and 0, and the control word reads back bits 23, 7:6, 4:3 and 1:0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive word at 0x24) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_in | input | 8 | IO line inputs |
| spi_io_out | output | 8 | IO line output values |
| spi_io_oe | output | 8 | IO line output enables |

## Verification
A table of transfers covers every width in both directions with byte counts of 1 to 4. Byte-reversed, asymmetric transmit words show whether byte order, bit order within a byte and lane order are right. Lane patterns held constant on the inputs differ per line and per width, so a wrong sampling line or a wrong lane-to-bit map yields a distinct receive value. Counting clock pulses and busy cycles separates a wrong alias decode from a wrong group count. Directed cases cover the phase setting, an abort mid-transfer, writes while disabled, the chip-select truth table and the masking of register fields on read-back.

// File: rtl/msio_pkg.sv
`timescale 1ns/1ps
package msio_pkg;
    localparam int REG_AW    = 8;
    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int IO_W      = 8;
    localparam int MAX_BYTES = WORD_W / BYTE_W;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    localparam logic [REG_AW-1:0] A_CFG = 8'h00;
    localparam logic [REG_AW-1:0] A_STS = 8'h04;
    localparam logic [REG_AW-1:0] A_EN  = 8'h10;
    localparam logic [REG_AW-1:0] A_TX0 = 8'h14;
    localparam logic [REG_AW-1:0] A_TX1 = 8'h18;
    localparam logic [REG_AW-1:0] A_TX2 = 8'h1C;
    localparam logic [REG_AW-1:0] A_TX3 = 8'h20;
    localparam logic [REG_AW-1:0] A_RX  = 8'h24;
    localparam logic [REG_AW-1:0] A_OPC = 8'h30;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2,
        LANE_X8 = 2'd3
    } lane_e;

    typedef struct packed {
        logic [1:0] nio;
        logic       cpha;
        logic       cpol;
        logic       idle_lvl;
        logic       man_cs;
        logic       cs_on;
    } cfg_t;

    typedef struct packed {
        logic  rd;
        lane_e data_w;
        lane_e addr_w;
        lane_e cmd_w;
    } opc_t;

    // Bit groups needed to move one byte at a given width
    function automatic logic [3:0] grp_per_byte(lane_e w);
        return 4'(8 >> w);
    endfunction
endpackage

// File: rtl/msio_regs.sv
`timescale 1ns/1ps
module msio_regs
    import msio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_AW-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] rdata,
    output cfg_t              cfg,
    output opc_t              opc,
    output logic              en,
    output logic              start,
    output logic [CNT_W-1:0]  start_bytes,
    output logic              rx_valid
);
    logic [WORD_W-1:0] rx_hold;
    logic              tx_hit;

    always_comb begin
        tx_hit      = 1'b1;
        start_bytes = CNT_W'(MAX_BYTES);
        case (addr)
            A_TX0:   start_bytes = CNT_W'(MAX_BYTES);
            A_TX1:   start_bytes = CNT_W'(1);
            A_TX2:   start_bytes = CNT_W'(2);
            A_TX3:   start_bytes = CNT_W'(3);
            default: tx_hit = 1'b0;
        endcase
        start = wr && tx_hit && en && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            opc      <= '{rd: 1'b0, data_w: LANE_X1, addr_w: LANE_X1, cmd_w: LANE_X1};
            en       <= 1'b0;
            rx_hold  <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (wr && addr == A_CFG) begin
                cfg.nio      <= wdata[28:27];
                cfg.cpha     <= wdata[20];
                cfg.cpol     <= wdata[19];
                cfg.idle_lvl <= wdata[16];
                cfg.man_cs   <= wdata[1];
                cfg.cs_on    <= wdata[0];
            end
            if (wr && addr == A_OPC) begin
                opc.rd     <= wdata[23];
                opc.data_w <= lane_e'(wdata[7:6]);
                opc.addr_w <= lane_e'(wdata[4:3]);
                opc.cmd_w  <= lane_e'(wdata[1:0]);
            end
            if (wr && addr == A_EN) en <= wdata[0];
            if (done) begin
                rx_hold  <= rx_word;
                rx_valid <= 1'b1;
            end else if (rd && addr == A_RX) begin
                rx_valid <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG: rdata = {3'b0, cfg.nio, 6'b0, cfg.cpha, cfg.cpol, 2'b0,
                            cfg.idle_lvl, 14'b0, cfg.man_cs, cfg.cs_on};
            A_STS: rdata = {28'b0, ~rx_valid, rx_valid, ~busy, ~busy};
            A_EN:  rdata = {31'b0, en};
            A_RX:  rdata = rx_hold;
            A_OPC: rdata = {8'b0, opc.rd, 15'b0, opc.data_w, 1'b0,
                            opc.addr_w, 1'b0, opc.cmd_w};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/msio_shift.sv
`timescale 1ns/1ps
module msio_shift
    import msio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_bytes,
    input  logic [WORD_W-1:0] start_data,
    input  lane_e             req_lanes,
    input  logic              req_rd,
    input  logic              cpha,
    input  logic [IO_W-1:0]   io_in,
    output logic              busy,
    output logic              ph,
    output lane_e             act_lanes,
    output logic              act_rd,
    output logic [BYTE_W-1:0] obyte,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] txw;
    logic [WORD_W-1:0] rxw;
    logic [BYTE_W-1:0] ibyte, ibyte_sh, ibyte_nx, obyte_sh;
    logic [CNT_W-1:0]  bytes_left;
    logic [3:0]        grp_left;
    logic              smp_now, grp_end, byte_end;

    always_comb begin
        case (act_lanes)
            LANE_X1: begin
                ibyte_sh = {ibyte[6:0], io_in[1]};
                obyte_sh = {obyte[6:0], 1'b0};
            end
            LANE_X2: begin
                ibyte_sh = {ibyte[5:0], io_in[1:0]};
                obyte_sh = {obyte[5:0], 2'b0};
            end
            LANE_X4: begin
                ibyte_sh = {ibyte[3:0], io_in[3:0]};
                obyte_sh = {obyte[3:0], 4'b0};
            end
            default: begin
                ibyte_sh = io_in;
                obyte_sh = '0;
            end
        endcase
        // leading edge samples when phase is clear, trailing edge when set
        smp_now  = cpha ? ph : ~ph;
        ibyte_nx = smp_now ? ibyte_sh : ibyte;
        grp_end  = busy & ph;
        byte_end = grp_end & (grp_left == 4'd1);
        done     = en & byte_end & (bytes_left == CNT_W'(1));
        rx_word  = {ibyte_nx, rxw[WORD_W-1:BYTE_W]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            ph         <= 1'b0;
            act_lanes  <= LANE_X1;
            act_rd     <= 1'b0;
            obyte      <= '0;
            ibyte      <= '0;
            txw        <= '0;
            rxw        <= '0;
            bytes_left <= '0;
            grp_left   <= '0;
        end else if (!en) begin
            busy <= 1'b0;
            ph   <= 1'b0;
        end else if (start) begin
            busy       <= 1'b1;
            ph         <= 1'b0;
            act_lanes  <= req_lanes;
            act_rd     <= req_rd;
            obyte      <= start_data[BYTE_W-1:0];
            txw        <= {{BYTE_W{1'b0}}, start_data[WORD_W-1:BYTE_W]};
            rxw        <= '0;
            ibyte      <= '0;
            bytes_left <= start_bytes;
            grp_left   <= grp_per_byte(req_lanes);
        end else if (busy) begin
            ph <= ~ph;
            if (smp_now) ibyte <= ibyte_sh;
            if (byte_end) begin
                rxw        <= rx_word;
                obyte      <= txw[BYTE_W-1:0];
                txw        <= {{BYTE_W{1'b0}}, txw[WORD_W-1:BYTE_W]};
                grp_left   <= grp_per_byte(act_lanes);
                bytes_left <= bytes_left - CNT_W'(1);
                if (bytes_left == CNT_W'(1)) busy <= 1'b0;
            end else if (grp_end) begin
                obyte    <= obyte_sh;
                grp_left <= grp_left - 4'd1;
            end
        end
    end
endmodule

// File: rtl/msio_pins.sv
`timescale 1ns/1ps
module msio_pins
    import msio_pkg::*;
(
    input  logic              busy,
    input  logic              ph,
    input  lane_e             lanes,
    input  logic              rd,
    input  logic [BYTE_W-1:0] obyte,
    input  cfg_t              cfg,
    output logic              sclk,
    output logic              cs_n,
    output logic [IO_W-1:0]   io_out,
    output logic [IO_W-1:0]   io_oe
);
    assign sclk = busy ? (cfg.cpol ^ (cfg.cpha ? ~ph : ph)) : cfg.cpol;
    assign cs_n = ~(cfg.man_cs & cfg.cs_on);

    for (genvar i = 0; i < IO_W; i++) begin : g_line
        localparam int IX2 = (i < 2) ? 6 + i : 0;
        localparam int IX4 = (i < 4) ? 4 + i : 0;
        logic used, bitv, drive;
        always_comb begin
            case (lanes)
                LANE_X1: begin used = (i == 0); bitv = obyte[7];   end
                LANE_X2: begin used = (i < 2);  bitv = obyte[IX2]; end
                LANE_X4: begin used = (i < 4);  bitv = obyte[IX4]; end
                default: begin used = 1'b1;     bitv = obyte[i];   end
            endcase
            drive = busy & ~rd & used;
        end
        assign io_oe[i]  = drive;
        assign io_out[i] = drive ? bitv : cfg.idle_lvl;
    end
endmodule

// File: rtl/msio_spi_host.sv
`timescale 1ns/1ps
module msio_spi_host
    import msio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    input  logic [IO_W-1:0]   spi_io_in,
    output logic [IO_W-1:0]   spi_io_out,
    output logic [IO_W-1:0]   spi_io_oe
);
    cfg_t              cfg_q;
    opc_t              opc_q;
    logic              en_q, start, sh_busy, sh_ph, sh_done, act_rd, rx_valid;
    logic [CNT_W-1:0]  start_bytes;
    logic [WORD_W-1:0] rx_word;
    logic [BYTE_W-1:0] obyte;
    lane_e             act_lanes;

    msio_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .busy(sh_busy), .done(sh_done), .rx_word(rx_word),
        .rdata(reg_rdata), .cfg(cfg_q), .opc(opc_q), .en(en_q), .start(start),
        .start_bytes(start_bytes), .rx_valid(rx_valid)
    );

    msio_shift u_shift (
        .clk(clk), .rst(rst), .en(en_q), .start(start),
        .start_bytes(start_bytes), .start_data(reg_wdata),
        .req_lanes(opc_q.data_w), .req_rd(opc_q.rd), .cpha(cfg_q.cpha),
        .io_in(spi_io_in), .busy(sh_busy), .ph(sh_ph), .act_lanes(act_lanes),
        .act_rd(act_rd), .obyte(obyte), .done(sh_done), .rx_word(rx_word)
    );

    msio_pins u_pins (
        .busy(sh_busy), .ph(sh_ph), .lanes(act_lanes), .rd(act_rd),
        .obyte(obyte), .cfg(cfg_q), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .io_out(spi_io_out), .io_oe(spi_io_oe)
    );
endmodule

// File: rtl/msio_spi_host_chk.sv
`timescale 1ns/1ps
module msio_spi_host_chk
    import msio_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            en,
    input logic            act_rd,
    input cfg_t            cfg,
    input logic            sclk,
    input logic            cs_n,
    input logic [IO_W-1:0] io_oe,
    input logic            rx_valid
);
    // R8
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.man_cs |-> cs_n);

    // R9
    sclk_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cfg.cpol));

    // R9
    sclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (sclk != $past(sclk)));

    // R7
    read_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && act_rd) |-> (io_oe == '0));

    // R10
    stop_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);

    // R5
    rx_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(busy));
endmodule

bind msio_spi_host msio_spi_host_chk u_chk (
    .clk(clk), .rst(rst), .busy(sh_busy), .en(en_q), .act_rd(act_rd),
    .cfg(cfg_q), .sclk(spi_sclk), .cs_n(spi_cs_n), .io_oe(spi_io_oe),
    .rx_valid(rx_valid)
);

// File: tb/sim_msio_spi_host.sv
`timescale 1ns/1ps
module sim_msio_spi_host;
    import msio_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  addr = 8'h04;
    logic [31:0] wdata = '0;
    logic [7:0]  io_in = '0;
    wire  [31:0] rdata;
    wire         sclk, cs_n;
    wire  [7:0]  io_out, io_oe;

    always #10 clk = ~clk;

    msio_spi_host u0 (
        .clk(clk), .rst(rst), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_io_in(io_in), .spi_io_out(io_out), .spi_io_oe(io_oe)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = A_STS;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0; addr = A_STS;
    endtask

    // serial monitor, valid for clock polarity 0 / phase 0
    logic        mon_on = 1'b0;
    int          edges = 0, oe_seen = 0, cur_l = 1;
    logic [31:0] cap = '0;
    always @(posedge sclk) if (mon_on) begin
        edges++;
        case (cur_l)
            1: cap = {cap[30:0], io_out[0]};
            2: cap = {cap[29:0], io_out[1:0]};
            4: cap = {cap[27:0], io_out[3:0]};
            default: cap = {cap[23:0], io_out};
        endcase
    end
    always @(negedge clk) if (mon_on && (|io_oe)) oe_seen++;

    function automatic logic [7:0] in_byte(input int l, input logic [7:0] p);
        case (l)
            1: return {8{p[1]}};
            2: return {4{p[1:0]}};
            4: return {2{p[3:0]}};
            default: return p;
        endcase
    endfunction

    function automatic logic [31:0] exp_rx(input int n, input logic [7:0] b);
        logic [31:0] r = '0;
        for (int k = 0; k < n; k++) r = {b, r[31:8]};
        return r;
    endfunction

    function automatic logic [31:0] exp_ser(input int n, input logic [31:0] w);
        logic [31:0] r = '0;
        for (int k = 0; k < n; k++) r = {r[23:0], w[8*k +: 8]};
        return r;
    endfunction

    // {lane code[1:0], read, alias[1:0], 3'b0, tx word[31:0], io_in[7:0]}
    localparam logic [47:0] VEC [0:7] = '{
        {2'd0, 1'b0, 2'd1, 3'b0, 32'h000000A5, 8'h02},
        {2'd0, 1'b0, 2'd0, 3'b0, 32'h44332211, 8'h00},
        {2'd1, 1'b0, 2'd2, 3'b0, 32'h0000C381, 8'h02},
        {2'd2, 1'b0, 2'd3, 3'b0, 32'h00563412, 8'h09},
        {2'd3, 1'b0, 2'd0, 3'b0, 32'hDEADBEEF, 8'h5A},
        {2'd3, 1'b1, 2'd1, 3'b0, 32'h00000000, 8'h3C},
        {2'd2, 1'b1, 2'd2, 3'b0, 32'h00000000, 8'h07},
        {2'd0, 1'b1, 2'd3, 3'b0, 32'h00000000, 8'h02}
    };

    initial begin
        #4000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        addr = A_STS; #1 check("R1 status", rdata, 32'h0000000B);
        addr = A_EN;  #1 check("R1 enable", rdata, 32'h0);
        check("R1 cs_n", {31'b0, cs_n}, 32'h1);
        check("R1 sclk", {31'b0, sclk}, 32'h0);
        check("R1 oe", {24'b0, io_oe}, 32'h0);
        check("R1 out", {24'b0, io_out}, 32'h0);
        addr = A_STS;

        // R10 disabled engine ignores transmit writes
        wr_reg(A_TX0, 32'h12345678);
        repeat (3) @(negedge clk);
        #1 check("R10 disabled tx", rdata, 32'h0000000B);

        // R8 chip select truth table
        wr_reg(A_CFG, 32'h1); #1 check("R8 assert only", {31'b0, cs_n}, 32'h1);
        wr_reg(A_CFG, 32'h2); #1 check("R8 manual only", {31'b0, cs_n}, 32'h1);
        wr_reg(A_CFG, 32'h3); #1 check("R8 both", {31'b0, cs_n}, 32'h0);
        wr_reg(A_EN, 32'h1);

        // R2 R3 R4 R5 R6 R7 vector table
        for (int v = 0; v < 8; v++) begin
            logic [1:0]  lc = VEC[v][47:46];
            logic        rdir = VEC[v][45];
            logic [1:0]  al = VEC[v][44:43];
            logic [31:0] tw = VEC[v][39:8];
            logic [7:0]  pins = VEC[v][7:0];
            int nb = (al == 2'd0) ? 4 : int'(al);
            int l = 1 << lc;
            wr_reg(A_OPC, {8'h0, rdir, 15'h0, lc, 6'h0});
            io_in = pins; cur_l = l; cap = '0; edges = 0; oe_seen = 0; mon_on = 1'b1;
            @(negedge clk);
            addr = A_TX0 + 8'(4 * al); wdata = tw; wr = 1'b1;
            @(negedge clk);
            wr = 1'b0; addr = A_STS;
            cnt = 0;
            #1;
            while (rdata[0] == 1'b0 && cnt < 500) begin
                cnt++;
                @(negedge clk); #1;
            end
            mon_on = 1'b0;
            check($sformatf("R5 busy cycles v%0d", v), cnt, 16 * nb / l);
            check($sformatf("R2 sclk pulses v%0d", v), edges, 8 * nb / l);
            if (!rdir)
                check($sformatf("R3 serial data v%0d", v), cap, exp_ser(nb, tw));
            else
                check($sformatf("R7 oe in read v%0d", v), oe_seen, 0);
            check($sformatf("R5 status done v%0d", v), rdata, 32'h00000007);
            rd_reg(A_RX, d);
            check($sformatf("R4 rx word v%0d", v), d, exp_rx(nb, in_byte(l, pins)));
            #1 check($sformatf("R6 popped v%0d", v), rdata, 32'h0000000B);
        end

        // R9 phase setting: first half of a group
        wr_reg(A_OPC, 32'h000000C0);
        @(negedge clk); addr = A_TX1; wdata = 32'h1; wr = 1'b1;
        @(negedge clk); wr = 1'b0; addr = A_STS;
        check("R9 cpha0 first half", {31'b0, sclk}, 32'h0);
        @(negedge clk); check("R9 cpha0 second half", {31'b0, sclk}, 32'h1);
        rd_reg(A_RX, d);
        wr_reg(A_CFG, 32'h00100003);
        @(negedge clk); addr = A_TX1; wdata = 32'h1; wr = 1'b1;
        @(negedge clk); wr = 1'b0; addr = A_STS;
        check("R9 cpha1 first half", {31'b0, sclk}, 32'h1);
        @(negedge clk); check("R9 cpha1 second half", {31'b0, sclk}, 32'h0);
        rd_reg(A_RX, d);

        // R10 abort mid-transfer
        wr_reg(A_CFG, 32'h3);
        wr_reg(A_OPC, 32'h0);
        wr_reg(A_TX0, 32'hFFFFFFFF);
        repeat (10) @(negedge clk);
        wr_reg(A_EN, 32'h0);
        repeat (2) @(negedge clk);
        #1 check("R10 abort status", rdata, 32'h0000000B);
        check("R10 abort sclk", {31'b0, sclk}, 32'h0);

        // R11 R12 idle level, clock polarity and field masking
        wr_reg(A_CFG, 32'hFFFFFFFF);
        addr = A_CFG; #1 check("R12 cfg readback", rdata, 32'h18190003);
        check("R11 idle level", {24'b0, io_out}, 32'h000000FF);
        check("R9 cpol idle", {31'b0, sclk}, 32'h1);
        wr_reg(A_OPC, 32'hFFFFFFFF);
        addr = A_OPC; #1 check("R12 opc readback", rdata, 32'h008000DB);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule